// File: doc/BRIEF.md
# FPM DRAM Access Cycle Sequencer

This block sits between a simple request/response host port and one fast-page-mode DRAM device. For each accepted request it runs one complete access cycle on the RAS#/CAS#/WE#/OE# strobes. It multiplexes the row and column onto the shared address pins. It controls when the block drives the data pins, and it captures the data returned by reads. Every phase length is a whole number of clocks, set by a parameter.

Four cycle kinds are supported, and each places WE# and OE# differently around the CAS# fall: a plain read, an early write, a late write and a read-modify-write. Every cycle opens with CAS# high for the row-to-column interval. That high interval is also the CAS# precharge pulse, which clears any stale output data in the device. Between cycles RAS# is held high for at least the precharge count. A board that grounds OE# is described by a parameter. In that build, late writes and read-modify-writes are turned into early writes.

Top module: `fpm_seq`

## Requirements
- R1: During and right after reset, RAS#, CAS#, WE# and OE# are high, the data drive enable and `rsp_valid` are low, and `req_ready` is high.
- R2: A request is taken on a clock where `req_valid` and `req_ready` are both high. `req_ready` is high only while no cycle is running. `req_op` encodes 0 = read, 1 = early write, 2 = late write, 3 = read-modify-write.
- R3: The row, zero-extended into the low bits of `dram_addr`, is on the pins when RAS# falls. The column, zero-extended the same way, is on the pins when CAS# falls.
- R4: Each cycle holds CAS# high for T_RCD clocks after RAS# falls. For reads, late writes and read-modify-writes, CAS# falls on the clock after that interval.
- R5: A read holds CAS# and OE# low for T_CAS clocks and samples `dq_in` as CAS# leaves that phase. It then pulses `rsp_valid` for one clock with the sampled word. WE# stays high for the whole read. RAS# is low for T_RCD+T_CAS clocks.
- R6: An early write drops WE# and drives data T_WCS clocks before CAS# falls. It keeps OE# high throughout, and WE# then stays low until RAS# rises. RAS# is low for T_RCD+T_WCS+T_CAS clocks.
- R7: A late write drops CAS# with WE# and OE# both high. WE# falls T_OD clocks later, with data driven, and stays low for T_WP clocks.
- R8: A read-modify-write reads as in R5 and keeps OE# low for T_LATCH further clocks. It then raises OE# for T_OD clocks before WE# falls for T_WP clocks with the new data, while CAS# stays low. `rsp_rdata` returns the word held before the write.
- R9: The data drive enable is high only while RAS# is low, WE# is low and OE# is high (OE# is ignored when it is tied low), and it is low whenever RAS# is high.
- R10: RAS# stays high for at least T_RP clocks between two cycles.
- R11: With OE_TIED_LOW set, `dram_oe_n` is always low. Late write and read-modify-write requests then run as early writes, with WE# low at the CAS# fall and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and precharged |
| req_op | input | 2 | Cycle kind (R2 encoding) |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wdata | input | DQ_W | Write data |
| rsp_valid | output | 1 | Read data valid, one clock |
| rsp_rdata | output | DQ_W | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed address |
| dq_out | output | DQ_W | Data toward the device |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| dq_in | input | DQ_W | Data from the device |

## Verification
The assertions assume `req_op` and the address and data fields are stable only on the accepting clock. They assume every timing parameter is at least one, and that `dq_in` carries the device word by the end of the CAS# read phase. The bench drives requests only when `req_ready` is seen, drops `req_valid` right after acceptance, and uses a behavioural device model. That model latches row and column on the strobe edges and presents its stored word whenever CAS# and OE# are low with WE# high, so read data meets the sampling point.

// File: rtl/fpm_pkg.sv
// Shared types for the FPM DRAM sequencer.
package fpm_pkg;
    // Host cycle kind; the code values are part of the port contract.
    typedef enum logic [1:0] {
        OP_READ     = 2'd0,
        OP_EARLY_WR = 2'd1,
        OP_LATE_WR  = 2'd2,
        OP_RMW      = 2'd3
    } op_e;

    // Sequencer phases; each lasts a parameterized number of clocks.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW,
        ST_WSETUP,
        ST_CAS_EW,
        ST_CAS_RD,
        ST_LATCH,
        ST_OE_OFF,
        ST_CAS_LW,
        ST_WE_LOW,
        ST_PRECH
    } seq_st_e;
endpackage

// File: rtl/fpm_timer.sv
// Phase timer: loads a count of (clocks - 1) on phase entry and counts down.
// Assumes the caller reloads on every phase change; done is high when the count is zero.
module fpm_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    // Down counter that rests at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // The count only moves down between loads.
    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && $past(cnt) != '0) |-> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/fpm_strobe_dec.sv
// Strobe decoder: maps the sequencer phase to the DRAM control pins.
// Assumes a Moore decode is acceptable; when OE_TIED_LOW is set, OE# is held low.
module fpm_strobe_dec
    import fpm_pkg::*;
#(
    parameter bit OE_TIED_LOW = 1'b0
) (
    input  seq_st_e state,
    output logic    ras_n,
    output logic    cas_n,
    output logic    we_n,
    output logic    oe_n,
    output logic    drive,
    output logic    sel_col
);
    logic oe_raw;

    // Phase to pin levels; everything inactive outside a cycle.
    always_comb begin
        ras_n   = 1'b1;
        cas_n   = 1'b1;
        we_n    = 1'b1;
        oe_raw  = 1'b1;
        drive   = 1'b0;
        sel_col = 1'b0;
        unique case (state)
            ST_ROW:    ras_n = 1'b0;
            ST_WSETUP: begin ras_n = 1'b0; we_n = 1'b0; drive = 1'b1; sel_col = 1'b1; end
            ST_CAS_EW: begin ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0; drive = 1'b1; sel_col = 1'b1; end
            ST_CAS_RD: begin ras_n = 1'b0; cas_n = 1'b0; oe_raw = 1'b0; sel_col = 1'b1; end
            ST_LATCH:  begin ras_n = 1'b0; cas_n = 1'b0; oe_raw = 1'b0; sel_col = 1'b1; end
            ST_OE_OFF: begin ras_n = 1'b0; cas_n = 1'b0; sel_col = 1'b1; end
            ST_CAS_LW: begin ras_n = 1'b0; cas_n = 1'b0; sel_col = 1'b1; end
            ST_WE_LOW: begin ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0; drive = 1'b1; sel_col = 1'b1; end
            default:   ;
        endcase
    end

    // Board-level tie of OE# overrides the decoded level.
    generate
        if (OE_TIED_LOW) begin : g_oe_tied
            assign oe_n = 1'b0;
        end else begin : g_oe_ctl
            assign oe_n = oe_raw;
        end
    endgenerate
endmodule

// File: rtl/fpm_addr_mux.sv
// Address multiplexer: puts the row or the column, zero-extended, on the shared pins.
// Assumes ADDR_W is at least the wider of the two fields.
module fpm_addr_mux #(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 10,
    parameter int ADDR_W = 12
) (
    input  logic              sel_col,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    output logic [ADDR_W-1:0] addr
);
    // Select the field for the current phase.
    always_comb begin
        addr = sel_col ? ADDR_W'(col) : ADDR_W'(row);
    end
endmodule

// File: rtl/fpm_seq.sv
// FPM DRAM access cycle sequencer: one host request becomes one full strobe cycle
// (read, early write, late write or read-modify-write). Assumes every timing
// parameter is at least 1 and that dq_in is valid by the end of the read phase.
module fpm_seq
    import fpm_pkg::*;
#(
    parameter int ROW_W       = 12,
    parameter int COL_W       = 10,
    parameter int DQ_W        = 4,
    parameter int T_RP        = 4,
    parameter int T_RCD       = 3,
    parameter int T_WCS       = 1,
    parameter int T_CAS       = 3,
    parameter int T_LATCH     = 1,
    parameter int T_OD        = 2,
    parameter int T_WP        = 2,
    parameter bit OE_TIED_LOW = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [1:0]                req_op,
    input  logic [ROW_W-1:0]          req_row,
    input  logic [COL_W-1:0]          req_col,
    input  logic [DQ_W-1:0]           req_wdata,
    output logic                      rsp_valid,
    output logic [DQ_W-1:0]           rsp_rdata,
    output logic                      dram_ras_n,
    output logic                      dram_cas_n,
    output logic                      dram_we_n,
    output logic                      dram_oe_n,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    output logic [DQ_W-1:0]           dq_out,
    output logic                      dq_oe,
    input  logic [DQ_W-1:0]           dq_in
);
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int CNT_W  = $clog2(T_RP + T_RCD + T_WCS + T_CAS + T_LATCH + T_OD + T_WP + 2);

    seq_st_e          state, state_n;
    op_e              op_q, op_in;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [DQ_W-1:0]  wdata_q;
    logic             t_done, t_load, sel_col;
    logic [CNT_W-1:0] t_val;

    assign req_ready = (state == ST_IDLE);

    // Convert writes that need OE# control when OE# is grounded.
    always_comb begin
        op_in = op_e'(req_op);
        if (OE_TIED_LOW && (op_in == OP_LATE_WR || op_in == OP_RMW)) op_in = OP_EARLY_WR;
    end

    // Phase sequencing.
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_n = ST_ROW;
            ST_ROW:    if (t_done) begin
                           unique case (op_q)
                               OP_READ, OP_RMW: state_n = ST_CAS_RD;
                               OP_EARLY_WR:     state_n = ST_WSETUP;
                               default:         state_n = ST_CAS_LW;
                           endcase
                       end
            ST_WSETUP: if (t_done) state_n = ST_CAS_EW;
            ST_CAS_EW: if (t_done) state_n = ST_PRECH;
            ST_CAS_RD: if (t_done) state_n = (op_q == OP_RMW) ? ST_LATCH : ST_PRECH;
            ST_LATCH:  if (t_done) state_n = ST_OE_OFF;
            ST_OE_OFF: if (t_done) state_n = ST_WE_LOW;
            ST_CAS_LW: if (t_done) state_n = ST_WE_LOW;
            ST_WE_LOW: if (t_done) state_n = ST_PRECH;
            ST_PRECH:  if (t_done) state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // Phase length (clocks - 1) loaded on entry to the next phase.
    always_comb begin
        t_load = (state_n != state);
        unique case (state_n)
            ST_ROW:    t_val = CNT_W'(T_RCD - 1);
            ST_WSETUP: t_val = CNT_W'(T_WCS - 1);
            ST_CAS_EW: t_val = CNT_W'(T_CAS - 1);
            ST_CAS_RD: t_val = CNT_W'(T_CAS - 1);
            ST_LATCH:  t_val = CNT_W'(T_LATCH - 1);
            ST_OE_OFF: t_val = CNT_W'(T_OD - 1);
            ST_CAS_LW: t_val = CNT_W'(T_OD - 1);
            ST_WE_LOW: t_val = CNT_W'(T_WP - 1);
            ST_PRECH:  t_val = CNT_W'(T_RP - 1);
            default:   t_val = '0;
        endcase
    end

    // State register and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            op_q    <= OP_READ;
            row_q   <= '0;
            col_q   <= '0;
            wdata_q <= '0;
        end else begin
            state <= state_n;
            if (req_valid && req_ready) begin
                op_q    <= op_in;
                row_q   <= req_row;
                col_q   <= req_col;
                wdata_q <= req_wdata;
            end
        end
    end

    // Read data capture at the end of the CAS# read phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (state == ST_CAS_RD) && t_done;
            if ((state == ST_CAS_RD) && t_done) rsp_rdata <= dq_in;
        end
    end

    fpm_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
    );

    fpm_strobe_dec #(.OE_TIED_LOW(OE_TIED_LOW)) u_dec (
        .state(state), .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
        .oe_n(dram_oe_n), .drive(dq_oe), .sel_col(sel_col)
    );

    fpm_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_mux (
        .sel_col(sel_col), .row(row_q), .col(col_q), .addr(dram_addr)
    );

    assign dq_out = wdata_q;

    // Clocks RAS# has been high, saturating; used only by the precharge check.
    logic [CNT_W-1:0] ras_hi_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)          ras_hi_cnt <= '1;
        else if (!dram_ras_n) ras_hi_cnt <= '0;
        else if (ras_hi_cnt != '1) ras_hi_cnt <= ras_hi_cnt + 1'b1;
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (dram_ras_n && dram_cas_n && !dq_oe && !rsp_valid));
    p_ready_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (dram_ras_n && dram_cas_n && dram_we_n));
    p_cas_in_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);
    p_rsp_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_we_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_we_n && !dram_ras_n) |=> (!dram_we_n || dram_ras_n));
    p_drive_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!dram_ras_n && !dram_we_n && (dram_oe_n || OE_TIED_LOW)));
    p_precharge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (ras_hi_cnt >= CNT_W'(T_RP)));
endmodule

// File: tb/tb_fpm_seq.sv
`timescale 1ns/1ps

// Behavioural device model: latches row and column on strobe falls, stores on
// write, and presents the stored word while CAS# and OE# are low with WE# high.
module tb_fpm_dram #(
    parameter int AW = 3,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic          dq_oe,
    input  logic [DW-1:0] dq_out,
    output logic [DW-1:0] dq_in,
    output logic [AW-1:0] row_q,
    output logic [AW-1:0] col_q
);
    logic [DW-1:0] mem [2**(2*AW)];
    logic p_ras = 1'b1, p_cas = 1'b1;

    initial begin
        row_q = '0;
        col_q = '0;
        for (int i = 0; i < 2**(2*AW); i++) mem[i] = DW'(i * 5 + 3);
    end

    always @(negedge clk) begin
        if (!ras_n && p_ras) row_q = addr;
        if (!ras_n && !cas_n && p_cas) col_q = addr;
        if (!ras_n && !cas_n && !we_n && dq_oe) mem[{row_q, col_q}] = dq_out;
        p_ras = ras_n;
        p_cas = cas_n;
    end

    assign dq_in = (!ras_n && !cas_n && !oe_n && we_n) ? mem[{row_q, col_q}] : DW'(10);
endmodule

module tb_fpm_seq;
    import fpm_pkg::*;

    localparam int RW = 3, CW = 3, DW = 4;
    localparam int TRP = 3, TRCD = 2, TWCS = 1, TCAS = 2, TLAT = 2, TOD = 1, TWP = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- main instance ----------------
    logic          req_valid = 1'b0, req_ready, rsp_valid;
    logic [1:0]    req_op = 2'd0;
    logic [RW-1:0] req_row = '0;
    logic [CW-1:0] req_col = '0;
    logic [DW-1:0] req_wdata = '0, rsp_rdata, dq_out, dq_in;
    logic          ras_n, cas_n, we_n, oe_n, dq_oe;
    logic [2:0]    dram_addr, m_row, m_col;

    fpm_seq #(.ROW_W(RW), .COL_W(CW), .DQ_W(DW), .T_RP(TRP), .T_RCD(TRCD), .T_WCS(TWCS),
              .T_CAS(TCAS), .T_LATCH(TLAT), .T_OD(TOD), .T_WP(TWP), .OE_TIED_LOW(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
        .dram_oe_n(oe_n), .dram_addr(dram_addr), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

    tb_fpm_dram #(.AW(3), .DW(DW)) m0 (
        .clk(clk), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .addr(dram_addr),
        .dq_oe(dq_oe), .dq_out(dq_out), .dq_in(dq_in), .row_q(m_row), .col_q(m_col));

    // ---------------- tied-OE instance ----------------
    logic          t_valid = 1'b0, t_ready, t_rsp_valid;
    logic [1:0]    t_op = 2'd0;
    logic [RW-1:0] t_row = '0;
    logic [CW-1:0] t_col = '0;
    logic [DW-1:0] t_wdata = '0, t_rdata, t_dq_out, t_dq_in;
    logic          t_ras_n, t_cas_n, t_we_n, t_oe_n, t_dq_oe;
    logic [2:0]    t_addr, t_mrow, t_mcol;

    fpm_seq #(.ROW_W(RW), .COL_W(CW), .DQ_W(DW), .T_RP(TRP), .T_RCD(TRCD), .T_WCS(TWCS),
              .T_CAS(TCAS), .T_LATCH(TLAT), .T_OD(TOD), .T_WP(TWP), .OE_TIED_LOW(1'b1)) dut_t (
        .clk(clk), .rst_n(rst_n), .req_valid(t_valid), .req_ready(t_ready), .req_op(t_op),
        .req_row(t_row), .req_col(t_col), .req_wdata(t_wdata), .rsp_valid(t_rsp_valid),
        .rsp_rdata(t_rdata), .dram_ras_n(t_ras_n), .dram_cas_n(t_cas_n), .dram_we_n(t_we_n),
        .dram_oe_n(t_oe_n), .dram_addr(t_addr), .dq_out(t_dq_out), .dq_oe(t_dq_oe), .dq_in(t_dq_in));

    tb_fpm_dram #(.AW(3), .DW(DW)) m1 (
        .clk(clk), .ras_n(t_ras_n), .cas_n(t_cas_n), .we_n(t_we_n), .oe_n(t_oe_n), .addr(t_addr),
        .dq_oe(t_dq_oe), .dq_out(t_dq_out), .dq_in(t_dq_in), .row_q(t_mrow), .col_q(t_mcol));

    // ---------------- reference state ----------------
    logic [DW-1:0] ref0 [64];
    logic [DW-1:0] ref1 [64];
    op_e           cur_op = OP_READ, cur_op_t = OP_READ;
    int            cur_a = 0;
    logic [DW-1:0] exp_rd = '0, exp_rd_t = '0;
    int            rsp_cnt = 0, rsp_exp = 0, rsp_cnt_t = 0, rsp_exp_t = 0;

    initial begin
        for (int i = 0; i < 64; i++) begin
            ref0[i] = DW'(i * 5 + 3);
            ref1[i] = DW'(i * 5 + 3);
        end
    end

    // ---------------- main strobe monitor ----------------
    logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, p_oe = 1'b1;
    int   ras_cnt = 0, cas_at = 0, we_at = 0, oe_rise_at = 0, hi_cnt = 100;
    bit   oe_low = 1'b0, bad_drive = 1'b0;

    task automatic end_check();
        int e_cas, e_we, e_oer, e_len;
        bit e_oel;
        string tg;
        e_oer = 0;
        case (cur_op)
            OP_READ:     begin tg = "R5"; e_cas = TRCD + 1; e_we = 0; e_len = TRCD + TCAS; e_oel = 1; end
            OP_EARLY_WR: begin tg = "R6"; e_we = TRCD + 1; e_cas = TRCD + TWCS + 1;
                               e_len = TRCD + TWCS + TCAS; e_oel = 0; end
            OP_LATE_WR:  begin tg = "R7"; e_cas = TRCD + 1; e_we = TRCD + TOD + 1;
                               e_len = TRCD + TOD + TWP; e_oel = 0; end
            default:     begin tg = "R8"; e_cas = TRCD + 1; e_oer = TRCD + TCAS + TLAT + 1;
                               e_we = e_oer + TOD; e_len = TRCD + TCAS + TLAT + TOD + TWP; e_oel = 1; end
        endcase
        chk(cas_at == e_cas, (cur_op == OP_EARLY_WR) ? "R6 cas fall" : "R4 cas fall", cas_at, e_cas);
        chk(we_at == e_we, {tg, " we fall"}, we_at, e_we);
        chk(oe_rise_at == e_oer, {tg, " oe rise"}, oe_rise_at, e_oer);
        chk(oe_low == e_oel, {tg, " oe low seen"}, int'(oe_low), int'(e_oel));
        chk(ras_cnt == e_len, {tg, " ras low length"}, ras_cnt, e_len);
        chk({m_row, m_col} == 6'(cur_a), "R3 row/col latched", int'({m_row, m_col}), cur_a);
        chk(!bad_drive && !dq_oe, "R9 drive window", int'(bad_drive), 0);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (!ras_n) begin
                if (p_ras) begin
                    chk(hi_cnt >= TRP, "R10 precharge", hi_cnt, TRP);
                    ras_cnt = 0; cas_at = 0; we_at = 0; oe_rise_at = 0;
                    oe_low = 1'b0; bad_drive = 1'b0; hi_cnt = 0;
                end
                ras_cnt++;
                if (!cas_n && p_cas) cas_at = ras_cnt;
                if (!we_n && p_we) we_at = ras_cnt;
                if (oe_n && !p_oe) oe_rise_at = ras_cnt;
                if (!oe_n) oe_low = 1'b1;
                if (dq_oe && (we_n || !oe_n)) bad_drive = 1'b1;
            end else begin
                if (!p_ras) end_check();
                hi_cnt++;
            end
            if (rsp_valid) begin
                rsp_cnt++;
                chk(rsp_rdata == exp_rd, (cur_op == OP_RMW) ? "R8 old data" : "R5 read data",
                    int'(rsp_rdata), int'(exp_rd));
            end
            p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_oe = oe_n;
        end
    end

    // ---------------- tied instance monitor ----------------
    logic tp_ras = 1'b1, tp_cas = 1'b1;
    bit   t_we_at_cas = 1'b1, t_oe_high = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (t_oe_n) t_oe_high = 1'b1;
            if (!t_ras_n && !t_cas_n && tp_cas) t_we_at_cas = t_we_n;
            if (t_ras_n && !tp_ras) begin
                if (cur_op_t != OP_READ)
                    chk(t_we_at_cas == 1'b0, "R11 write runs early", int'(t_we_at_cas), 0);
                chk(!t_oe_high, "R11 oe tied low", int'(t_oe_high), 0);
            end
            if (t_rsp_valid) begin
                rsp_cnt_t++;
                chk(t_rdata == exp_rd_t, "R11 read after converted write", int'(t_rdata), int'(exp_rd_t));
            end
            tp_ras = t_ras_n; tp_cas = t_cas_n;
        end
    end

    // ---------------- drivers ----------------
    task automatic issue(input op_e op, input int a, input logic [DW-1:0] wd);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_op    = 2'(op);
        req_row   = RW'(a >> 3);
        req_col   = CW'(a & 7);
        req_wdata = wd;
        cur_op    = op;
        cur_a     = a;
        if (op == OP_READ || op == OP_RMW) begin exp_rd = ref0[a]; rsp_exp++; end
        if (op != OP_READ) ref0[a] = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
    endtask

    task automatic issue_t(input op_e op, input int a, input logic [DW-1:0] wd);
        @(negedge clk);
        while (!t_ready) @(negedge clk);
        t_valid   = 1'b1;
        t_op      = 2'(op);
        t_row     = RW'(a >> 3);
        t_col     = CW'(a & 7);
        t_wdata   = wd;
        cur_op_t  = op;
        t_oe_high = 1'b0;
        if (op == OP_READ) begin exp_rd_t = ref1[a]; rsp_exp_t++; end
        else ref1[a] = wd;
        @(negedge clk);
        t_valid = 1'b0;
        while (!t_ready) @(negedge clk);
    endtask

    task automatic read_all();
        for (int a = 0; a < 64; a++) issue(OP_READ, a, '0);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(ras_n && cas_n && we_n && oe_n, "R1 strobes high in reset",
            int'({ras_n, cas_n, we_n, oe_n}), 15);
        chk(!dq_oe && !rsp_valid, "R1 drive and rsp low in reset", int'({dq_oe, rsp_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && ras_n && cas_n, "R1 ready after reset", int'({req_ready, ras_n, cas_n}), 7);
        chk(!req_ready || t_ready, "R2 both idle", int'(t_ready), 1);

        for (int a = 0; a < 64; a++) issue(OP_EARLY_WR, a, DW'(a * 3 + 1));
        read_all();
        for (int a = 0; a < 64; a++) issue(OP_LATE_WR, a, DW'(a * 7 + 2));
        read_all();
        for (int a = 0; a < 64; a++) issue(OP_RMW, a, DW'(a + 9));
        read_all();
        // Mixed back-to-back kinds on one location.
        for (int k = 0; k < 8; k++) issue(op_e'(k % 4), 42, DW'(k + 5));
        issue(OP_READ, 42, '0);
        chk(rsp_cnt == rsp_exp, "R2 one response per read", rsp_cnt, rsp_exp);

        issue_t(OP_LATE_WR, 5, 4'd6);
        issue_t(OP_RMW, 9, 4'd12);
        issue_t(OP_READ, 5, '0);
        issue_t(OP_READ, 9, '0);
        issue_t(OP_EARLY_WR, 1, 4'd3);
        issue_t(OP_READ, 1, '0);
        chk(rsp_cnt_t == rsp_exp_t, "R11 no response for converted rmw", rsp_cnt_t, rsp_exp_t);

        repeat (4) @(negedge clk);
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule